// File: doc/BRIEF.md
# Load-Multiple Micro-Op Sequencer

This block turns one load-multiple instruction into a run of single-register memory reads. The instruction arrives as a 16-bit register-selection mask, the index of the base register and the base address held in that register, and is taken in over a valid/ready handshake. The sequencer then walks the mask from its lowest set bit to its highest. For each selected register it issues one memory-read micro-op carrying the word address, the base-register index and the destination-register index. Alongside each micro-op it requests one reorder-buffer slot.

Unselected registers cost nothing: with both downstream ports ready, an instruction selecting N registers occupies exactly N consecutive step cycles. A selected bit 15 names the program counter, and the micro-op flags it as such. Once a sequence starts it cannot be interrupted: new instructions are refused until the last step has gone out. A one-cycle completion pulse marks the end of each instruction, including one whose mask is empty.

The memory, the register file and the reorder-buffer storage lie outside the block. They appear only as a memory-request port and a slot-allocation port, and each step advances only when both are ready in the same cycle.

Top module: `lmSeqTop`

## Requirements
- R1: After reset, `inReady` is 1 and `memValid`, `robValid` and `done` are 0.
- R2: `inReady` is 1 exactly when no step of an earlier instruction is still pending. An instruction is taken on a clock edge where `inValid` and `inReady` are both 1.
- R3: An accepted instruction produces one step for each bit set to 1 in `inMask`, and none for bits set to 0. When `memReady` and `robReady` stay at 1, the steps occupy consecutive cycles starting the cycle after acceptance, with no idle cycle between them.
- R4: Steps go in ascending bit order. Each step's `memDestIdx` equals the position k of the mask bit it serves, where bit k selects register k.
- R5: The step serving the n-th selected register (n counted from 0) carries `memAddr` = `inBaseAddr` + 4·n, taken modulo 2^32.
- R6: Every step of an instruction carries on `memBaseIdx` the `inBaseIdx` given at acceptance.
- R7: `memWritesPc` is 1 exactly when the current step's destination index is 15, and 0 for every other index.
- R8: `robValid` equals `memValid` in every cycle. A step completes only on an edge where `memReady` and `robReady` are both 1. Otherwise it stays presented, with address and indices unchanged.
- R9: While steps remain, `inReady` is 0, and `inValid` together with the other input fields has no effect on the steps in progress.
- R10: `done` is 1 for exactly the one cycle after the edge on which an instruction's final step completes.
- R11: An all-zero mask produces no step, and `done` is 1 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Sequencer idle, instruction can be taken |
| inMask | input | 16 | Register-selection mask, bit k selects register k |
| inBaseIdx | input | 4 | Index of the base register |
| inBaseAddr | input | 32 | Base address read from the base register |
| memValid | output | 1 | Memory-read micro-op presented |
| memReady | input | 1 | Memory port can take the micro-op |
| memAddr | output | 32 | Word address of this read |
| memBaseIdx | output | 4 | Base-register index read by this step |
| memDestIdx | output | 4 | Register written by this step |
| memWritesPc | output | 1 | Destination is the program counter (index 15) |
| robValid | output | 1 | Reorder-buffer slot requested for this step |
| robReady | input | 1 | Reorder buffer can grant a slot |
| done | output | 1 | One-cycle pulse at instruction completion |

## Verification
The completion pulse of one instruction and the acceptance of the next can fall in the same cycle. The sequencer drops back to idle on the edge that sends the final step, so `done` and `inReady` are high together. The bench provokes this by presenting each new instruction at the very cycle it checks the previous `done`, with back-to-back empty masks as the sharpest case. It then judges that the new instruction's first step appears on the next cycle with its own base, address and index, while the old pulse lasts exactly one cycle.

// File: rtl/lmSeqPkg.sv
package lmSeqPkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a newly accepted instruction
    logic advance;  // current step transferred, move to next set bit
  } seqStrobes_t;

endpackage

// File: rtl/lmSeqCtrl.sv
module lmSeqCtrl
  import lmSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inMaskZero,
  input  logic        lastStep,
  input  logic        memReady,
  input  logic        robReady,
  output logic        inReady,
  output logic        stepValid,
  output logic        done,
  output seqStrobes_t strobes
);

  seqState_t state;
  seqState_t stateNext;
  logic      accept;
  logic      fire;
  logic      doneQ;

  assign inReady   = (state == SEQ_IDLE);
  assign stepValid = (state == SEQ_RUN);
  assign accept    = inValid && inReady;
  // both downstream ports must take the step together
  assign fire      = stepValid && memReady && robReady;

  assign strobes.load    = accept;
  assign strobes.advance = fire;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE: if (accept && !inMaskZero) stateNext = SEQ_RUN;
      SEQ_RUN:  if (fire && lastStep)      stateNext = SEQ_IDLE;
      default:                             stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= (accept && inMaskZero) || (fire && lastStep);
    end
  end

  assign done = doneQ;

endmodule

// File: rtl/lmSeqDatapath.sv
module lmSeqDatapath
  import lmSeqPkg::*;
#(
  parameter int MASK_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4,
  localparam int IDX_W     = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [MASK_W-1:0] inMask,
  input  logic [IDX_W-1:0]  inBaseIdx,
  input  logic [ADDR_W-1:0] inBaseAddr,
  output logic [ADDR_W-1:0] stepAddr,
  output logic [IDX_W-1:0]  stepBaseIdx,
  output logic [IDX_W-1:0]  stepDestIdx,
  output logic              stepWritesPc,
  output logic              lastStep
);

  localparam logic [IDX_W-1:0]  PC_IDX   = IDX_W'(MASK_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP_BYTES);

  logic [MASK_W-1:0] remMask;
  logic [MASK_W-1:0] nextMask;
  logic [MASK_W-1:0] firstHot;
  logic [MASK_W:0]   anyBelow;
  logic [ADDR_W-1:0] curAddr;
  logic [IDX_W-1:0]  baseIdxQ;

  // prefix chain that isolates the lowest remaining set bit
  assign anyBelow[0] = 1'b0;
  for (genvar b = 0; b < MASK_W; b++) begin : g_pick
    assign firstHot[b]   = remMask[b] && !anyBelow[b];
    assign anyBelow[b+1] = anyBelow[b] || remMask[b];
  end

  always_comb begin
    stepDestIdx = '0;
    for (int b = 0; b < MASK_W; b++) begin
      if (firstHot[b]) stepDestIdx = stepDestIdx | IDX_W'(b);
    end
  end

  assign nextMask     = remMask & ~firstHot;
  assign lastStep     = (nextMask == '0);
  assign stepWritesPc = (stepDestIdx == PC_IDX);
  assign stepAddr     = curAddr;
  assign stepBaseIdx  = baseIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remMask  <= '0;
      curAddr  <= '0;
      baseIdxQ <= '0;
    end else if (strobes.load) begin
      remMask  <= inMask;
      curAddr  <= inBaseAddr;
      baseIdxQ <= inBaseIdx;
    end else if (strobes.advance) begin
      remMask  <= nextMask;
      curAddr  <= curAddr + ADDR_INC;
    end
  end

endmodule

// File: rtl/lmSeqTop.sv
module lmSeqTop
  import lmSeqPkg::*;
#(
  parameter int MASK_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4,
  localparam int IDX_W     = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [MASK_W-1:0] inMask,
  input  logic [IDX_W-1:0]  inBaseIdx,
  input  logic [ADDR_W-1:0] inBaseAddr,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [IDX_W-1:0]  memBaseIdx,
  output logic [IDX_W-1:0]  memDestIdx,
  output logic              memWritesPc,
  output logic              robValid,
  input  logic              robReady,
  output logic              done
);

  seqStrobes_t strobes;
  logic        lastStep;
  logic        stepValid;

  lmSeqCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inMaskZero (inMask == '0),
    .lastStep   (lastStep),
    .memReady   (memReady),
    .robReady   (robReady),
    .inReady    (inReady),
    .stepValid  (stepValid),
    .done       (done),
    .strobes    (strobes)
  );

  lmSeqDatapath #(
    .MASK_W     (MASK_W),
    .ADDR_W     (ADDR_W),
    .STEP_BYTES (STEP_BYTES)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .inMask       (inMask),
    .inBaseIdx    (inBaseIdx),
    .inBaseAddr   (inBaseAddr),
    .stepAddr     (memAddr),
    .stepBaseIdx  (memBaseIdx),
    .stepDestIdx  (memDestIdx),
    .stepWritesPc (memWritesPc),
    .lastStep     (lastStep)
  );

  assign memValid = stepValid;
  assign robValid = stepValid;

endmodule

// File: rtl/lmSeqChecker.sv
module lmSeqChecker #(
  parameter int MASK_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4,
  localparam int IDX_W     = $clog2(MASK_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [MASK_W-1:0] inMask,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [IDX_W-1:0]  memBaseIdx,
  input logic [IDX_W-1:0]  memDestIdx,
  input logic              memWritesPc,
  input logic              robValid,
  input logic              robReady,
  input logic              done
);

  logic stepFire;
  assign stepFire = memValid && memReady && robReady;

  // R8: slot request accompanies every memory step
  a_r8_rob_with_mem: assert property (@(posedge clk) disable iff (!rstN)
    robValid == memValid);

  // R8: a stalled step holds its payload
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !(memReady && robReady) |=>
      memValid && $stable(memAddr) && $stable(memDestIdx) && $stable(memBaseIdx));

  // R9: no new instruction is taken while steps are pending
  a_r9_no_preempt: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !inReady);

  // R4: destinations strictly rise inside one instruction
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rstN)
    stepFire |=> !memValid || (memDestIdx > $past(memDestIdx)));

  // R5: address advances one word per step
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    stepFire |=> !memValid || (memAddr == $past(memAddr) + ADDR_W'(STEP_BYTES)));

  // R6: base index constant across the steps of one instruction
  a_r6_base_stable: assert property (@(posedge clk) disable iff (!rstN)
    stepFire |=> !memValid || $stable(memBaseIdx));

  // R7: program-counter flag tracks the top index
  a_r7_pc_flag: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memWritesPc == (memDestIdx == IDX_W'(MASK_W - 1))));

  // R11: empty mask completes at once
  a_r11_empty_done: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (inMask == '0) |=> done && !memValid);

  // R3: a non-empty mask starts stepping on the next cycle
  a_r3_first_step: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && (inMask != '0) |=> memValid && !done);

  // R10: completion never overlaps a presented step
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memValid && inReady);

endmodule

bind lmSeqTop lmSeqChecker #(
  .MASK_W     (MASK_W),
  .ADDR_W     (ADDR_W),
  .STEP_BYTES (STEP_BYTES)
) i_lmSeqChecker (.*);

// File: tb/test_lmSeqTop.sv
module test_lmSeqTop;

  localparam int MASK_W = 16;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [MASK_W-1:0] inMask = '0;
  logic [IDX_W-1:0]  inBaseIdx = '0;
  logic [ADDR_W-1:0] inBaseAddr = '0;
  logic              memValid;
  logic              memReady = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [IDX_W-1:0]  memBaseIdx;
  logic [IDX_W-1:0]  memDestIdx;
  logic              memWritesPc;
  logic              robValid;
  logic              robReady = 1'b0;
  logic              done;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;  // 250 MHz

  lmSeqTop i_lmSeqTop (.*);

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int popCount(input logic [MASK_W-1:0] m);
    int c = 0;
    for (int b = 0; b < MASK_W; b++) c += int'(m[b]);
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] nthSetBit(input logic [MASK_W-1:0] m, input int n);
    int seen = 0;
    for (int b = 0; b < MASK_W; b++) begin
      if (m[b]) begin
        if (seen == n) return IDX_W'(b);
        seen++;
      end
    end
    return '0;
  endfunction

  // Starts at a negedge; returns at the negedge where done is checked,
  // so a following call presents its instruction in that same cycle.
  task automatic runInstr(input logic [MASK_W-1:0] m, input logic [IDX_W-1:0] bi,
                          input logic [ADDR_W-1:0] ba, input int readyPct);
    int n = popCount(m);
    int k = 0;
    logic [ADDR_W-1:0] expAddr;
    logic [IDX_W-1:0]  expDest;
    bit fire;
    check(inReady == 1'b1, "R2 inReady idle", 32'(inReady), 32'd1);
    inValid = 1'b1; inMask = m; inBaseIdx = bi; inBaseAddr = ba;
    @(posedge clk); @(negedge clk);
    while (k < n) begin
      memReady = ($urandom_range(99) < readyPct);
      robReady = ($urandom_range(99) < readyPct);
      // R9: noise on the input while busy, quiet on the final step
      inValid    = (k < n - 1) ? 1'($urandom_range(1)) : 1'b0;
      inMask     = 16'($urandom);
      inBaseIdx  = 4'($urandom);
      inBaseAddr = $urandom;
      expAddr = ba + ADDR_W'(4 * k);
      expDest = nthSetBit(m, k);
      check(memValid == 1'b1, "R3 step presented", 32'(memValid), 32'd1);
      check(robValid == memValid, "R8 rob with mem", 32'(robValid), 32'(memValid));
      check(memDestIdx == expDest, "R4 dest order", 32'(memDestIdx), 32'(expDest));
      check(memAddr == expAddr, "R5 address", memAddr, expAddr);
      check(memBaseIdx == bi, "R6 base index", 32'(memBaseIdx), 32'(bi));
      check(memWritesPc == (expDest == 4'd15), "R7 pc flag",
            32'(memWritesPc), 32'(expDest == 4'd15));
      check(inReady == 1'b0, "R9 busy refuses", 32'(inReady), 32'd0);
      check(done == 1'b0, "R10 no early done", 32'(done), 32'd0);
      fire = memReady && robReady;
      @(posedge clk); @(negedge clk);
      if (fire) k++;
    end
    inValid = 1'b0;
    memReady = 1'b0; robReady = 1'b0;
    if (n == 0)
      check(done == 1'b1, "R11 empty done", 32'(done), 32'd1);
    else
      check(done == 1'b1, "R10 done pulse", 32'(done), 32'd1);
    check(memValid == 1'b0, "R3 no extra step", 32'(memValid), 32'd0);
  endtask

  task automatic idle(input int cycles);
    inValid = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk); @(negedge clk);
      check(done == 1'b0, "R10 single cycle", 32'(done), 32'd0);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(inReady == 1'b1 && memValid == 1'b0 && robValid == 1'b0 && done == 1'b0,
          "R1 reset state", {28'd0, inReady, memValid, robValid, done}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runInstr(16'h0000, 4'd3, 32'h0000_1000, 100);   // R11
    idle(1);
    runInstr(16'hFFFF, 4'd13, 32'h0000_2000, 100);  // R3 no gaps, R7
    idle(1);
    runInstr(16'h8000, 4'd1, 32'h0000_3000, 100);   // R7 only pc
    idle(1);
    runInstr(16'h0001, 4'd0, 32'hFFFF_FFFC, 100);   // R5 low bit
    runInstr(16'hA800, 4'd13, 32'hFFFF_FFF8, 100);  // R5 wrap, back-to-back
    runInstr(16'h0000, 4'd2, 32'h0, 100);           // empty after done
    runInstr(16'h0000, 4'd2, 32'h0, 100);           // empty back-to-back
    runInstr(16'h4001, 4'd7, 32'h0000_4000, 30);    // R8 heavy stalls
    idle(2);

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [MASK_W-1:0] m = 16'($urandom);
      if ($urandom_range(9) == 0) m = '0;
      else if ($urandom_range(4) == 0) m = m & 16'($urandom) & 16'($urandom);
      runInstr(m, 4'($urandom), {$urandom} & ~32'h3,
               ($urandom_range(2) == 0) ? 100 : 60);
      if ($urandom_range(2) == 0) idle($urandom_range(3));
    end
    idle(2);
    finishRun();
  end

endmodule